// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in front of the ALU of a five-stage in-order pipeline. It takes the two source register indices of the instruction now in execute. It compares them with the destination indices of the two older instructions still in flight. From that comparison it decides, for each operand, whether the ALU should take the register-file read value, the result sitting in the execute/memory register, or the value about to be written back. It also drives the two ALU operands.

When both older instructions write the register being read, the younger of the two (the one in execute/memory) wins. A stage whose write enable is low never supplies a value. Register 0 is never bypassed. After the bypass choice, operand B goes through one more multiplexer that can replace it with the sign-extended immediate.

The block is purely combinational. Each select is a 2-bit code: 00 means register file, 01 means writeback value, and 10 means execute/memory result. Stall detection, the register file, the ALU and the pipeline registers live elsewhere.

Top module: `operand_bypass`

## Requirements
- R1: A select is 2'b10 whenever the execute/memory write enable is high, its destination is nonzero and the destination equals that operand's source index (index A for select A, index B for select B).
- R2: A select is 2'b01 whenever the writeback write enable is high, its destination is nonzero, it equals that operand's source index, and the R1 condition for that operand does not hold.
- R3: A select is 2'b00 when neither R1 nor R2 holds. The operand then equals its register-file read value unchanged.
- R4: When both older stages write the source register, the select is 2'b10 and the operand equals the execute/memory result.
- R5: A stage whose write enable is low never causes a bypass, even when its destination matches.
- R6: A destination of register 0 never causes a bypass, even with its write enable high and a source index of 0.
- R7: With the ALU-source input high, operand B equals the immediate while select B still reports the bypass choice. Operand A does not depend on the ALU-source input.
- R8: A select of 2'b10 makes the operand equal to the execute/memory result. A select of 2'b01 makes it equal to the writeback value.
- R9: No select ever takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register index of the instruction in execute |
| src_b_idx | input | 5 | Second source register index of the instruction in execute |
| exmem_dst | input | 5 | Destination index held in the execute/memory register |
| exmem_we | input | 1 | Register write enable held in the execute/memory register |
| memwb_dst | input | 5 | Destination index held in the memory/writeback register |
| memwb_we | input | 1 | Register write enable held in the memory/writeback register |
| rf_a_data | input | 32 | Register-file read value for the first source |
| rf_b_data | input | 32 | Register-file read value for the second source |
| exmem_result | input | 32 | ALU result held in the execute/memory register |
| wb_value | input | 32 | Value being written back from the memory/writeback register |
| imm_ext | input | 32 | Sign-extended immediate of the instruction in execute |
| alu_src_imm | input | 1 | High: operand B is the immediate |
| fwd_sel_a | output | 2 | Bypass select for operand A (00 register file, 01 writeback, 10 execute/memory) |
| fwd_sel_b | output | 2 | Bypass select for operand B, same encoding |
| alu_opnd_a | output | 32 | Final ALU operand A |
| alu_opnd_b | output | 32 | Final ALU operand B |

## Verification
The bench replays a dependency chain in which one result is consumed one, two and three instructions later. It also replays a run of three back-to-back writes to the same register. A design that reversed the stage priority would hand the stale writeback value to the third instruction. The bench also drives matching indices with the write enables low and with register 0 as destination, where a careless comparator bypasses a value the register file never holds. Finally it sets the immediate select while a bypass is pending. Placing the immediate mux before the bypass mux would let the bypassed value leak onto operand B.

// File: rtl/operand_bypass_pkg.sv
// Shared definitions for the execute-stage operand bypass selector.
// Assumes one consumer stage (execute) and two producer stages.
package operand_bypass_pkg;

    // Bypass select encoding seen at the ports; FWD_RSVD is never produced.
    typedef enum logic [1:0] {
        FWD_RF   = 2'b00,
        FWD_WB   = 2'b01,
        FWD_MEM  = 2'b10,
        FWD_RSVD = 2'b11
    } fwd_sel_e;

    // Number of ALU operands that may be bypassed.
    localparam int unsigned NUM_OPND = 2;

    // Index of each operand inside the per-operand arrays.
    localparam int unsigned OPND_A = 0;
    localparam int unsigned OPND_B = 1;

endpackage

// File: rtl/bypass_match.sv
// Compares one source index against the two in-flight destinations and
// picks the bypass source. The younger (execute/memory) stage has priority.
// Assumes index 0 is the hard-wired zero register and is never bypassed.
module bypass_match
    import operand_bypass_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic             mem_we,
    input  logic [IDX_W-1:0] wb_dst,
    input  logic             wb_we,
    output fwd_sel_e         sel
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic hit_mem;
    logic hit_wb;

    // Qualify each producer: it must write, target a real register, and match.
    always_comb begin
        hit_mem = mem_we && (mem_dst != ZERO_IDX) && (mem_dst == src_idx);
        hit_wb  = wb_we  && (wb_dst  != ZERO_IDX) && (wb_dst  == src_idx);
    end

    // Priority choice: the younger result shadows the older one.
    always_comb begin
        if (hit_mem) begin
            sel = FWD_MEM;
        end else if (hit_wb) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_RF;
        end
    end

endmodule

// File: rtl/operand_mux.sv
// Three-source operand selector driven by a bypass select.
// The unused code falls back to the register-file value.
module operand_mux
    import operand_bypass_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] out_val
);

    // Route the chosen source; the reserved code behaves like FWD_RF.
    always_comb begin
        unique case (sel)
            FWD_MEM: out_val = mem_val;
            FWD_WB:  out_val = wb_val;
            default: out_val = rf_val;
        endcase
    end

endmodule

// File: rtl/imm_select.sv
// Second-level selector on operand B: bypassed register value or immediate.
// Assumes the immediate is already sign-extended to DATA_W.
module imm_select #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] imm_val,
    output logic [DATA_W-1:0] out_val
);

    // Choose the immediate when the instruction asks for it.
    always_comb begin
        out_val = use_imm ? imm_val : reg_val;
    end

endmodule

// File: rtl/operand_bypass.sv
// Execute-stage operand bypass selector. For each ALU operand it finds the
// newest in-flight producer of the source register and routes its value;
// operand B then passes through the immediate selector.
// Assumes purely combinational use between the decode/execute register and
// the ALU; stall decisions are made elsewhere.
module operand_bypass
    import operand_bypass_pkg::*;
#(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [IDX_W-1:0]  exmem_dst,
    input  logic              exmem_we,
    input  logic [IDX_W-1:0]  memwb_dst,
    input  logic              memwb_we,
    input  logic [DATA_W-1:0] rf_a_data,
    input  logic [DATA_W-1:0] rf_b_data,
    input  logic [DATA_W-1:0] exmem_result,
    input  logic [DATA_W-1:0] wb_value,
    input  logic [DATA_W-1:0] imm_ext,
    input  logic              alu_src_imm,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic [DATA_W-1:0] alu_opnd_a,
    output logic [DATA_W-1:0] alu_opnd_b
);

    logic [IDX_W-1:0]  src_idx [NUM_OPND];
    logic [DATA_W-1:0] rf_val  [NUM_OPND];
    fwd_sel_e          sel     [NUM_OPND];
    logic [DATA_W-1:0] byp_val [NUM_OPND];

    // Gather per-operand inputs into arrays for the generate loop.
    always_comb begin
        src_idx[OPND_A] = src_a_idx;
        src_idx[OPND_B] = src_b_idx;
        rf_val[OPND_A]  = rf_a_data;
        rf_val[OPND_B]  = rf_b_data;
    end

    // One comparator and one bypass mux per operand.
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        bypass_match #(
            .IDX_W (IDX_W)
        ) u_match (
            .src_idx (src_idx[g]),
            .mem_dst (exmem_dst),
            .mem_we  (exmem_we),
            .wb_dst  (memwb_dst),
            .wb_we   (memwb_we),
            .sel     (sel[g])
        );

        operand_mux #(
            .DATA_W (DATA_W)
        ) u_mux (
            .sel     (sel[g]),
            .rf_val  (rf_val[g]),
            .mem_val (exmem_result),
            .wb_val  (wb_value),
            .out_val (byp_val[g])
        );
    end

    // The immediate choice comes after bypassing, on operand B only.
    imm_select #(
        .DATA_W (DATA_W)
    ) u_imm (
        .use_imm (alu_src_imm),
        .reg_val (byp_val[OPND_B]),
        .imm_val (imm_ext),
        .out_val (alu_opnd_b)
    );

    // Drive the remaining outputs.
    always_comb begin
        fwd_sel_a  = sel[OPND_A];
        fwd_sel_b  = sel[OPND_B];
        alu_opnd_a = byp_val[OPND_A];
    end

endmodule

// File: rtl/operand_bypass_chk.sv
// Assertion checker for operand_bypass, attached by bind below.
// The block has no clock, so the checks are immediate assertions on settled values.
module operand_bypass_chk #(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input logic [IDX_W-1:0]  src_a_idx,
    input logic [IDX_W-1:0]  src_b_idx,
    input logic [IDX_W-1:0]  exmem_dst,
    input logic              exmem_we,
    input logic [IDX_W-1:0]  memwb_dst,
    input logic              memwb_we,
    input logic [DATA_W-1:0] rf_a_data,
    input logic [DATA_W-1:0] exmem_result,
    input logic [DATA_W-1:0] wb_value,
    input logic [DATA_W-1:0] imm_ext,
    input logic              alu_src_imm,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic [DATA_W-1:0] alu_opnd_a,
    input logic [DATA_W-1:0] alu_opnd_b
);

    logic mem_a, mem_b, wb_a, wb_b;

    // Independent statement of the producer conditions.
    always_comb begin
        mem_a = exmem_we && (exmem_dst != '0) && (exmem_dst == src_a_idx);
        mem_b = exmem_we && (exmem_dst != '0) && (exmem_dst == src_b_idx);
        wb_a  = memwb_we && (memwb_dst != '0) && (memwb_dst == src_a_idx);
        wb_b  = memwb_we && (memwb_dst != '0) && (memwb_dst == src_b_idx);
    end

    // Relate port-level selects and operands to the producer conditions.
    always_comb begin
        if (mem_a) a_r1_mem_sel_a: assert (fwd_sel_a == 2'b10);
        if (mem_b) a_r1_mem_sel_b: assert (fwd_sel_b == 2'b10);
        if (!mem_a && wb_a) a_r2_wb_sel_a: assert (fwd_sel_a == 2'b01);
        if (!mem_b && wb_b) a_r2_wb_sel_b: assert (fwd_sel_b == 2'b01);
        if (fwd_sel_a == 2'b00) a_r3_rf_pass_a: assert (alu_opnd_a == rf_a_data);
        if (!exmem_we && !memwb_we) a_r5_no_we_a: assert (fwd_sel_a == 2'b00);
        if (src_a_idx == '0) a_r6_zero_reg_a: assert (fwd_sel_a == 2'b00);
        if (alu_src_imm) a_r7_imm_b: assert (alu_opnd_b == imm_ext);
        if (fwd_sel_a == 2'b10) a_r8_mem_val_a: assert (alu_opnd_a == exmem_result);
        if (fwd_sel_a == 2'b01) a_r8_wb_val_a: assert (alu_opnd_a == wb_value);
        a_r9_no_rsvd_a: assert (fwd_sel_a != 2'b11);
        a_r9_no_rsvd_b: assert (fwd_sel_b != 2'b11);
    end

endmodule

bind operand_bypass operand_bypass_chk #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
) u_chk (
    .src_a_idx    (src_a_idx),
    .src_b_idx    (src_b_idx),
    .exmem_dst    (exmem_dst),
    .exmem_we     (exmem_we),
    .memwb_dst    (memwb_dst),
    .memwb_we     (memwb_we),
    .rf_a_data    (rf_a_data),
    .exmem_result (exmem_result),
    .wb_value     (wb_value),
    .imm_ext      (imm_ext),
    .alu_src_imm  (alu_src_imm),
    .fwd_sel_a    (fwd_sel_a),
    .fwd_sel_b    (fwd_sel_b),
    .alu_opnd_a   (alu_opnd_a),
    .alu_opnd_b   (alu_opnd_b)
);

// File: tb/operand_bypass_bench.sv
// Scoreboard bench: the driver applies a pipeline snapshot and queues the
// hand-derived selects; the monitor compares on the falling edge.
module operand_bypass_bench;

    localparam logic [31:0] RF_A = 32'h1111_1111;
    localparam logic [31:0] RF_B = 32'h2222_2222;
    localparam logic [31:0] MEMR = 32'h3333_3333;
    localparam logic [31:0] WBV  = 32'h4444_4444;
    localparam logic [31:0] IMM  = 32'hFFFF_FF9C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [4:0]  src_a_idx = '0, src_b_idx = '0, exmem_dst = '0, memwb_dst = '0;
    logic        exmem_we = 1'b0, memwb_we = 1'b0, alu_src_imm = 1'b0;
    logic [31:0] rf_a_data = RF_A, rf_b_data = RF_B, exmem_result = MEMR;
    logic [31:0] wb_value = WBV, imm_ext = IMM;
    logic [1:0]  fwd_sel_a, fwd_sel_b;
    logic [31:0] alu_opnd_a, alu_opnd_b;

    operand_bypass u_operand_bypass (
        .src_a_idx    (src_a_idx),
        .src_b_idx    (src_b_idx),
        .exmem_dst    (exmem_dst),
        .exmem_we     (exmem_we),
        .memwb_dst    (memwb_dst),
        .memwb_we     (memwb_we),
        .rf_a_data    (rf_a_data),
        .rf_b_data    (rf_b_data),
        .exmem_result (exmem_result),
        .wb_value     (wb_value),
        .imm_ext      (imm_ext),
        .alu_src_imm  (alu_src_imm),
        .fwd_sel_a    (fwd_sel_a),
        .fwd_sel_b    (fwd_sel_b),
        .alu_opnd_a   (alu_opnd_a),
        .alu_opnd_b   (alu_opnd_b)
    );

    typedef struct {
        string       tag;
        logic [1:0]  sa;
        logic [1:0]  sb;
        logic [31:0] oa;
        logic [31:0] ob;
    } exp_t;

    exp_t scb[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    // Operand implied by a select code (R8 / R3 encoding).
    function automatic logic [31:0] pick(logic [1:0] s, logic [31:0] rf);
        case (s)
            2'b10:   return MEMR;
            2'b01:   return WBV;
            default: return rf;
        endcase
    endfunction

    // Driver: apply one snapshot after a rising edge and queue its expectation.
    task automatic drive(string tag, logic [4:0] sa, logic [4:0] sb,
                         logic [4:0] md, logic mwe, logic [4:0] wd, logic wwe,
                         logic imm, logic [1:0] ea, logic [1:0] eb);
        exp_t e;
        @(posedge clk);
        #1;
        src_a_idx = sa; src_b_idx = sb;
        exmem_dst = md; exmem_we = mwe;
        memwb_dst = wd; memwb_we = wwe;
        alu_src_imm = imm;
        e.tag = tag; e.sa = ea; e.sb = eb;
        e.oa = pick(ea, RF_A);
        e.ob = imm ? IMM : pick(eb, RF_B);
        scb.push_back(e);
    endtask

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop and compare away from the driving edge.
    always @(negedge clk) begin
        if (scb.size() > 0) begin
            exp_t e;
            e = scb.pop_front();
            cmp(e.tag, "sel_a", {30'd0, fwd_sel_a}, {30'd0, e.sa});
            cmp(e.tag, "sel_b", {30'd0, fwd_sel_b}, {30'd0, e.sb});
            cmp(e.tag, "opnd_a", alu_opnd_a, e.oa);
            cmp(e.tag, "opnd_b", alu_opnd_b, e.ob);
            if (fwd_sel_a == 2'b11 || fwd_sel_b == 2'b11) begin
                n_checks++; n_errors++;
                $display("FAIL R9 %s: actual 11 expected not 11", e.tag);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R3: idle pipeline after reset, nothing bypassed
        drive("R3 reset",            5'd0, 5'd0, 5'd0, 0, 5'd0, 0, 0, 2'b00, 2'b00);
        // Chain: sub r2 ; and r4,r2,r5 ; or r4,r4,r2 ; add r9,r4,r2
        drive("R1 and-after-sub",    5'd2, 5'd5, 5'd2, 1, 5'd0, 0, 0, 2'b10, 2'b00);
        drive("R2 or-r2-from-wb",    5'd4, 5'd2, 5'd4, 1, 5'd2, 1, 0, 2'b10, 2'b01);
        drive("R4 add-r4-both",      5'd4, 5'd2, 5'd4, 1, 5'd4, 1, 0, 2'b10, 2'b00);
        // Triple write to r1: add r1 ; add r1,r1,r3 ; add r1,r1,r4
        drive("R1 r1-second",        5'd1, 5'd3, 5'd1, 1, 5'd0, 0, 0, 2'b10, 2'b00);
        drive("R4 r1-third",         5'd1, 5'd4, 5'd1, 1, 5'd1, 1, 0, 2'b10, 2'b00);
        drive("R4 both-on-b",        5'd7, 5'd6, 5'd6, 1, 5'd6, 1, 0, 2'b00, 2'b10);
        // R5: enables low
        drive("R5 both-we-low",      5'd8, 5'd8, 5'd8, 0, 5'd8, 0, 0, 2'b00, 2'b00);
        drive("R5 mem-we-low",       5'd8, 5'd9, 5'd8, 0, 5'd8, 1, 0, 2'b01, 2'b00);
        drive("R5 wb-we-low",        5'd3, 5'd3, 5'd9, 1, 5'd3, 0, 0, 2'b00, 2'b00);
        // R6: register 0
        drive("R6 zero-both",        5'd0, 5'd0, 5'd0, 1, 5'd0, 1, 0, 2'b00, 2'b00);
        drive("R6 zero-mem-wb-ok",   5'd0, 5'd0, 5'd0, 1, 5'd5, 1, 0, 2'b00, 2'b00);
        // R2: writeback only, and mem on another register
        drive("R2 wb-a-and-b",       5'd11, 5'd11, 5'd12, 1, 5'd11, 1, 0, 2'b01, 2'b01);
        drive("R8 split-sources",    5'd12, 5'd11, 5'd12, 1, 5'd11, 1, 0, 2'b10, 2'b01);
        // R7: immediate overrides operand B after bypass
        drive("R7 imm-over-mem",     5'd13, 5'd14, 5'd14, 1, 5'd13, 1, 1, 2'b01, 2'b10);
        drive("R7 imm-no-bypass",    5'd20, 5'd21, 5'd0, 0, 5'd0, 0, 1, 2'b00, 2'b00);
        drive("R7 opnd-a-kept",      5'd14, 5'd15, 5'd14, 1, 5'd0, 0, 1, 2'b10, 2'b00);
        drive("R3 index-mismatch",   5'd30, 5'd31, 5'd29, 1, 5'd28, 1, 0, 2'b00, 2'b00);
        drive("R1 top-index",        5'd31, 5'd31, 5'd31, 1, 5'd0, 1, 0, 2'b10, 2'b10);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule